// File: doc/BRIEF.md
# Slot hotplug register controller

This block keeps the hotplug bookkeeping for a bank of up to 32 expansion slots and presents it to software as four 32-bit words in a 16-byte I/O window. It holds three masks: which slots hold a device, which slots may be hot-removed, and which slots have a removal request that software has not yet serviced. Slot events arrive as single-cycle pulses that carry a slot number. A live insert or a removal request produces a one-cycle pulse on `gpeSet`, and the surrounding logic uses that pulse to set the hotplug bit (value 0x02) of its general-purpose event status register.

Software services removals by writing the eject word. Only the lowest set bit of the written value is taken as the slot. The block then emits a one-cycle eject strobe for that slot, which the teardown logic consumes. The word presented as "inserted" is not stored. It is built on every read from the present mask and the removable mask.

A system reset request makes the block eject every outstanding removal, one slot per cycle starting from the lowest. It then reloads the removable mask from the strap vector. Power-on reset clears all state, and the removable mask is loaded one cycle after reset is released.

Top module: `hp_slot_ctrl`

## Requirements
- R1: The register read is combinational on `regWord`, the byte offset divided by 4. Word 0 (offset 0x0) returns present AND removable. Word 1 (0x4) returns the pending-removal mask. Word 2 (0x8) always returns 0. Word 3 (0xC) returns the removable mask. Bit n of each word is slot n.
- R2: `evtInsert` with `evtCold`=0 sets the present bit of `evtSlot` at the next clock edge, and `gpeSet` is high for exactly the cycle after that edge.
- R3: `evtInsert` with `evtCold`=1 sets the present bit and leaves `gpeSet` low.
- R4: `evtRemove` sets the pending bit of `evtSlot` at the next edge and pulses `gpeSet` for one cycle.
- R5: A write of a nonzero value to word 2 selects the slot given by the lowest set bit of the value. At the next edge it clears that slot's pending bit and drives `ejectStrobe` one-hot on that slot for one cycle. It clears the slot's present bit only when `fixedOccupied` is 0 for that slot.
- R6: A write of zero to word 2 has no effect, and writes to words 0, 1 and 3 have no effect: no strobe, and no mask changes.
- R7: When an event and an eject hit the same slot at the same edge, the event wins. A removal event keeps the pending bit set, and an insert event keeps the present bit set. The eject strobe is still produced.
- R8: A `sysResetReq` pulse starts a drain at the next edge. On each following edge the lowest pending slot is ejected under the R5 rules. On the first edge with nothing pending, the removable mask is loaded with NOT `fixedStrap` and the drain ends. Writes to word 2 during a drain are ignored.
- R9: While `rstN` is low, all masks, `ejectStrobe` and `gpeSet` are zero. At the first edge after release the removable mask is loaded with NOT `fixedStrap`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low power-on reset |
| sysResetReq | input | 1 | Pulse: start the removal drain and reload the removable mask |
| evtInsert | input | 1 | Pulse: a device was inserted in `evtSlot` |
| evtRemove | input | 1 | Pulse: removal requested for `evtSlot` |
| evtSlot | input | 5 | Slot number of the current event |
| evtCold | input | 1 | Insert happened while the machine was being built (no event raised) |
| fixedStrap | input | 32 | Per-slot strap, 1 = slot is not removable |
| fixedOccupied | input | 32 | Per-slot, 1 = slot holds a device that cannot be hot-removed |
| regWord | input | 2 | Word select in the window (byte offset / 4) |
| regWr | input | 1 | Write strobe for the selected word |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for the selected word |
| gpeSet | output | 1 | One-cycle pulse to set the hotplug status bit |
| ejectStrobe | output | 32 | One-hot one-cycle eject strobe per slot |

## Verification
The hardest case to reach from the ports is a collision at a single edge: an event and an eject on the same slot, or a software eject write arriving while the reset drain is running. The stimulus reaches the first by driving the event pulse and the eject write in the same cycle. It reaches the second by queueing three removals on scattered slots, firing a system reset request, and issuing an eject write for an unrelated slot in the drain's first cycle. The checks then confirm that the strobes come out in ascending slot order, one per cycle, that the stray write leaves no trace, and that the removable mask picks up a strap vector changed just before the request.

// File: rtl/hp_pkg.sv
package hp_pkg;
  localparam int unsigned HP_SLOTS  = 32;
  localparam int unsigned HP_SLOT_W = $clog2(HP_SLOTS);
  localparam int unsigned HP_DATA_W = 32;

  typedef enum logic [1:0] {
    WORD_INSERTED  = 2'd0,
    WORD_PENDING   = 2'd1,
    WORD_EJECT     = 2'd2,
    WORD_REMOVABLE = 2'd3
  } hpWord_e;

  typedef struct packed {
    logic                ejectEn;
    logic [HP_SLOTS-1:0] ejectSel;
    logic                loadCap;
  } hpCtl_t;
endpackage

// File: rtl/hp_control.sv
module hp_control
  import hp_pkg::*;
#(
  parameter int unsigned SLOTS  = HP_SLOTS,
  parameter int unsigned DATA_W = HP_DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sysResetReq,
  input  logic              regWr,
  input  logic [1:0]        regWord,
  input  logic [DATA_W-1:0] regWdata,
  input  logic [SLOTS-1:0]  pendingMask,
  output hpCtl_t            ctl,
  output logic              draining
);
  typedef enum logic {ST_IDLE, ST_DRAIN} ctlState_e;

  ctlState_e state, stateNext;
  logic [SLOTS-1:0] wrBits;
  logic [SLOTS-1:0] wrLow;
  logic [SLOTS-1:0] pendLow;
  logic             anyPending;
  logic             wrEject;

  assign wrBits     = regWdata[SLOTS-1:0];
  assign wrLow      = wrBits & (~wrBits + SLOTS'(1));
  assign pendLow    = pendingMask & (~pendingMask + SLOTS'(1));
  assign anyPending = |pendingMask;
  assign wrEject    = regWr && (regWord == WORD_EJECT) && (|wrBits) && (state == ST_IDLE);
  assign draining   = (state == ST_DRAIN);

  always_comb begin
    ctl.ejectEn  = 1'b0;
    ctl.ejectSel = '0;
    ctl.loadCap  = 1'b0;
    if (state == ST_DRAIN) begin
      if (anyPending) begin
        ctl.ejectEn  = 1'b1;
        ctl.ejectSel = pendLow;
      end else begin
        ctl.loadCap = 1'b1;
      end
    end else if (wrEject) begin
      ctl.ejectEn  = 1'b1;
      ctl.ejectSel = wrLow;
    end
  end

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE:  if (sysResetReq) stateNext = ST_DRAIN;
      ST_DRAIN: if (!anyPending) stateNext = sysResetReq ? ST_DRAIN : ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_DRAIN;
    else       state <= stateNext;
  end
endmodule

// File: rtl/hp_datapath.sv
module hp_datapath
  import hp_pkg::*;
#(
  parameter int unsigned SLOTS  = HP_SLOTS,
  parameter int unsigned SLOT_W = HP_SLOT_W,
  parameter int unsigned DATA_W = HP_DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  hpCtl_t            ctl,
  input  logic              evtInsert,
  input  logic              evtRemove,
  input  logic [SLOT_W-1:0] evtSlot,
  input  logic              evtCold,
  input  logic [SLOTS-1:0]  fixedStrap,
  input  logic [SLOTS-1:0]  fixedOccupied,
  input  logic [1:0]        regWord,
  output logic [DATA_W-1:0] regRdata,
  output logic [SLOTS-1:0]  presentMask,
  output logic [SLOTS-1:0]  pendingMask,
  output logic [SLOTS-1:0]  capableMask,
  output logic [SLOTS-1:0]  ejectStrobe,
  output logic              gpeSet
);
  logic [SLOTS-1:0] presentNext, pendingNext, capableNext, strobeNext;

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    logic insHit, remHit, ejHit;
    assign insHit = evtInsert && (evtSlot == SLOT_W'(i));
    assign remHit = evtRemove && (evtSlot == SLOT_W'(i));
    assign ejHit  = ctl.ejectEn && ctl.ejectSel[i];

    always_comb begin
      presentNext[i] = presentMask[i];
      if (insHit)                           presentNext[i] = 1'b1;
      else if (ejHit && !fixedOccupied[i])  presentNext[i] = 1'b0;

      pendingNext[i] = pendingMask[i];
      if (remHit)     pendingNext[i] = 1'b1;
      else if (ejHit) pendingNext[i] = 1'b0;

      capableNext[i] = ctl.loadCap ? ~fixedStrap[i] : capableMask[i];
      strobeNext[i]  = ejHit;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      presentMask <= '0;
      pendingMask <= '0;
      capableMask <= '0;
      ejectStrobe <= '0;
      gpeSet      <= 1'b0;
    end else begin
      presentMask <= presentNext;
      pendingMask <= pendingNext;
      capableMask <= capableNext;
      ejectStrobe <= strobeNext;
      gpeSet      <= (evtInsert && !evtCold) || evtRemove;
    end
  end

  always_comb begin
    case (regWord)
      WORD_INSERTED:  regRdata = DATA_W'(presentMask & capableMask);
      WORD_PENDING:   regRdata = DATA_W'(pendingMask);
      WORD_REMOVABLE: regRdata = DATA_W'(capableMask);
      default:        regRdata = '0;
    endcase
  end
endmodule

// File: rtl/hp_slot_ctrl.sv
module hp_slot_ctrl
  import hp_pkg::*;
#(
  parameter int unsigned SLOTS  = HP_SLOTS,
  parameter int unsigned SLOT_W = HP_SLOT_W,
  parameter int unsigned DATA_W = HP_DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sysResetReq,
  input  logic              evtInsert,
  input  logic              evtRemove,
  input  logic [SLOT_W-1:0] evtSlot,
  input  logic              evtCold,
  input  logic [SLOTS-1:0]  fixedStrap,
  input  logic [SLOTS-1:0]  fixedOccupied,
  input  logic [1:0]        regWord,
  input  logic              regWr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              gpeSet,
  output logic [SLOTS-1:0]  ejectStrobe
);
  hpCtl_t           ctlStrobes;
  logic             drainActive;
  logic [SLOTS-1:0] presentMask, pendingMask, capableMask;

  hp_control #(.SLOTS(SLOTS), .DATA_W(DATA_W)) i_control (
    .clk(clk), .rstN(rstN), .sysResetReq(sysResetReq), .regWr(regWr),
    .regWord(regWord), .regWdata(regWdata), .pendingMask(pendingMask),
    .ctl(ctlStrobes), .draining(drainActive)
  );

  hp_datapath #(.SLOTS(SLOTS), .SLOT_W(SLOT_W), .DATA_W(DATA_W)) i_datapath (
    .clk(clk), .rstN(rstN), .ctl(ctlStrobes), .evtInsert(evtInsert),
    .evtRemove(evtRemove), .evtSlot(evtSlot), .evtCold(evtCold),
    .fixedStrap(fixedStrap), .fixedOccupied(fixedOccupied), .regWord(regWord),
    .regRdata(regRdata), .presentMask(presentMask), .pendingMask(pendingMask),
    .capableMask(capableMask), .ejectStrobe(ejectStrobe), .gpeSet(gpeSet)
  );
endmodule

// File: rtl/hp_slot_ctrl_chk.sv
module hp_slot_ctrl_chk
  import hp_pkg::*;
#(
  parameter int unsigned SLOTS  = HP_SLOTS,
  parameter int unsigned SLOT_W = HP_SLOT_W,
  parameter int unsigned DATA_W = HP_DATA_W
) (
  input logic              clk,
  input logic              rstN,
  input logic              evtInsert,
  input logic              evtRemove,
  input logic [SLOT_W-1:0] evtSlot,
  input logic              evtCold,
  input logic [1:0]        regWord,
  input logic [DATA_W-1:0] regRdata,
  input logic              gpeSet,
  input logic [SLOTS-1:0]  ejectStrobe,
  input logic [SLOTS-1:0]  presentMask,
  input logic [SLOTS-1:0]  pendingMask
);
  p_feature_zero_r1: assert property (@(posedge clk) disable iff (!rstN)
    (regWord == 2'd2) |-> (regRdata == '0));

  p_hot_insert_r2: assert property (@(posedge clk) disable iff (!rstN)
    (evtInsert && !evtCold) |=> (gpeSet && presentMask[$past(evtSlot)]));

  p_cold_quiet_r3: assert property (@(posedge clk) disable iff (!rstN)
    (evtInsert && evtCold && !evtRemove) |=> !gpeSet);

  p_remove_flag_r4: assert property (@(posedge clk) disable iff (!rstN)
    evtRemove |=> (gpeSet && pendingMask[$past(evtSlot)]));

  p_eject_onehot_r5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(ejectStrobe));

  p_eject_clears_r5: assert property (@(posedge clk) disable iff (!rstN)
    ((|ejectStrobe) && !$past(evtRemove)) |-> ((pendingMask & ejectStrobe) == '0));
endmodule

bind hp_slot_ctrl hp_slot_ctrl_chk #(.SLOTS(SLOTS), .SLOT_W(SLOT_W), .DATA_W(DATA_W)) i_chk (
  .clk(clk), .rstN(rstN), .evtInsert(evtInsert), .evtRemove(evtRemove),
  .evtSlot(evtSlot), .evtCold(evtCold), .regWord(regWord), .regRdata(regRdata),
  .gpeSet(gpeSet), .ejectStrobe(ejectStrobe), .presentMask(presentMask),
  .pendingMask(pendingMask)
);

// File: tb/test_hp_slot_ctrl.sv
module test_hp_slot_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sysResetReq = 1'b0;
  logic        evtInsert = 1'b0;
  logic        evtRemove = 1'b0;
  logic [4:0]  evtSlot = '0;
  logic        evtCold = 1'b0;
  logic [31:0] fixedStrap = 32'h0000_0011;
  logic [31:0] fixedOccupied = 32'h0000_0100;
  logic [1:0]  regWord = 2'd3;
  logic        regWr = 1'b0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        gpeSet;
  logic [31:0] ejectStrobe;

  int    checks = 0;
  int    errors = 0;
  bit    started = 0;
  bit    finished = 0;
  string curReq = "R9";

  hp_slot_ctrl i_hp_slot_ctrl (
    .clk(clk), .rstN(rstN), .sysResetReq(sysResetReq), .evtInsert(evtInsert),
    .evtRemove(evtRemove), .evtSlot(evtSlot), .evtCold(evtCold),
    .fixedStrap(fixedStrap), .fixedOccupied(fixedOccupied), .regWord(regWord),
    .regWr(regWr), .regWdata(regWdata), .regRdata(regRdata), .gpeSet(gpeSet),
    .ejectStrobe(ejectStrobe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural reference model
  bit [31:0] mPresent = 0, mPending = 0, mCap = 0, mStrobe = 0;
  bit        mGpe = 0, mDrain = 1;

  function automatic int lowestBit(input bit [31:0] v);
    for (int i = 0; i < 32; i++) if (v[i]) return i;
    return -1;
  endfunction

  function automatic bit [31:0] modelRead(input logic [1:0] w);
    case (w)
      2'd0: return mPresent & mCap;
      2'd1: return mPending;
      2'd3: return mCap;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    started <= 1;
    if (!rstN) begin
      mPresent = 0; mPending = 0; mCap = 0; mStrobe = 0; mGpe = 0; mDrain = 1;
    end else begin
      int  sel;
      bit  load;
      bit  wasEmpty;
      sel = -1;
      load = 0;
      wasEmpty = (mPending == 0);
      if (mDrain) begin
        if (!wasEmpty) sel = lowestBit(mPending);
        else load = 1;
      end else if (regWr && regWord == 2'd2 && regWdata != 0) begin
        sel = lowestBit(regWdata);
      end
      mStrobe = 0;
      if (sel >= 0) begin
        mStrobe[sel] = 1;
        mPending[sel] = 0;
        if (!fixedOccupied[sel]) mPresent[sel] = 0;
      end
      if (evtInsert) mPresent[evtSlot] = 1;
      if (evtRemove) mPending[evtSlot] = 1;
      if (load) mCap = ~fixedStrap;
      mGpe = (evtInsert && !evtCold) || evtRemove;
      if (mDrain) begin
        if (wasEmpty) mDrain = sysResetReq;
      end else if (sysResetReq) mDrain = 1;
    end
  end

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started && !finished) begin
      check({31'd0, gpeSet}, {31'd0, mGpe}, curReq, "model gpeSet");
      check(ejectStrobe, mStrobe, curReq, "model ejectStrobe");
      check(regRdata, modelRead(regWord), curReq, "model regRdata");
    end
  end

  task automatic clearPulses();
    evtInsert = 0; evtRemove = 0; regWr = 0; sysResetReq = 0;
  endtask

  task automatic pulseInsert(input int slot, input bit cold);
    @(posedge clk); #1;
    evtInsert = 1; evtSlot = 5'(slot); evtCold = cold;
    @(posedge clk); #1;
    clearPulses();
  endtask

  task automatic pulseRemove(input int slot);
    @(posedge clk); #1;
    evtRemove = 1; evtSlot = 5'(slot);
    @(posedge clk); #1;
    clearPulses();
  endtask

  task automatic writeReg(input logic [1:0] w, input logic [31:0] d);
    @(posedge clk); #1;
    regWr = 1; regWord = w; regWdata = d;
    @(posedge clk); #1;
    clearPulses();
  endtask

  task automatic readWord(input logic [1:0] w, input logic [31:0] exp, input string tag);
    @(posedge clk); #1;
    regWord = w;
    @(negedge clk);
    check(regRdata, exp, tag, $sformatf("read word %0d", w));
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] drainExp [3];
    drainExp[0] = 32'h0000_0004;
    drainExp[1] = 32'h0000_0040;
    drainExp[2] = 32'h0000_0200;

    // R9: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(regRdata, 32'h0, "R9", "removable during reset");
    check(ejectStrobe, 32'h0, "R9", "strobe during reset");
    check({31'd0, gpeSet}, 32'h0, "R9", "gpeSet during reset");
    @(posedge clk); #1;
    rstN = 1;
    @(posedge clk);
    @(negedge clk);
    check(regRdata, 32'hFFFF_FFEE, "R9", "removable loaded after release");

    // R3: cold insert
    curReq = "R3";
    pulseInsert(3, 1);
    @(negedge clk);
    check({31'd0, gpeSet}, 32'h0, "R3", "no event on cold insert");
    readWord(0, 32'h0000_0008, "R3");

    // R2: hot insert
    curReq = "R2";
    pulseInsert(5, 0);
    @(negedge clk);
    check({31'd0, gpeSet}, 32'h1, "R2", "event on hot insert");
    readWord(0, 32'h0000_0028, "R2");

    // R1: insert into non-removable slot, feature word, removable word
    curReq = "R1";
    pulseInsert(4, 0);
    readWord(0, 32'h0000_0028, "R1");
    readWord(2, 32'h0, "R1");
    readWord(3, 32'hFFFF_FFEE, "R1");
    pulseInsert(8, 0);

    // R4: removal requests
    curReq = "R4";
    pulseRemove(5);
    @(negedge clk);
    check({31'd0, gpeSet}, 32'h1, "R4", "event on removal");
    pulseRemove(8);
    readWord(1, 32'h0000_0120, "R4");

    // R5: eject, lowest bit only, fixed device keeps present
    curReq = "R5";
    writeReg(2, 32'h0000_0120);
    @(negedge clk);
    check(ejectStrobe, 32'h0000_0020, "R5", "strobe lowest slot");
    readWord(1, 32'h0000_0100, "R5");
    readWord(0, 32'h0000_0108, "R5");
    writeReg(2, 32'h0000_0100);
    @(negedge clk);
    check(ejectStrobe, 32'h0000_0100, "R5", "strobe fixed slot");
    readWord(1, 32'h0, "R5");
    readWord(0, 32'h0000_0108, "R5");

    // R6: writes with no effect
    curReq = "R6";
    writeReg(2, 32'h0);
    @(negedge clk);
    check(ejectStrobe, 32'h0, "R6", "zero eject write");
    writeReg(0, 32'hFFFF_FFFF);
    writeReg(1, 32'hFFFF_FFFF);
    writeReg(3, 32'h0000_0000);
    @(negedge clk);
    check(ejectStrobe, 32'h0, "R6", "read-only writes");
    readWord(3, 32'hFFFF_FFEE, "R6");
    readWord(1, 32'h0, "R6");
    readWord(0, 32'h0000_0108, "R6");

    // R7: same-edge collisions
    curReq = "R7";
    @(posedge clk); #1;
    evtRemove = 1; evtSlot = 5'd3; regWr = 1; regWord = 2'd2; regWdata = 32'h8;
    @(posedge clk); #1;
    clearPulses();
    @(negedge clk);
    check(ejectStrobe, 32'h0000_0008, "R7", "strobe with removal collision");
    readWord(1, 32'h0000_0008, "R7");
    readWord(0, 32'h0000_0100, "R7");
    @(posedge clk); #1;
    evtInsert = 1; evtCold = 0; evtSlot = 5'd3; regWr = 1; regWord = 2'd2; regWdata = 32'h8;
    @(posedge clk); #1;
    clearPulses();
    @(negedge clk);
    check(ejectStrobe, 32'h0000_0008, "R7", "strobe with insert collision");
    readWord(1, 32'h0, "R7");
    readWord(0, 32'h0000_0108, "R7");

    // R8: drain on system reset request
    curReq = "R8";
    fixedStrap = 32'h0000_0003;
    pulseRemove(9);
    pulseRemove(2);
    pulseRemove(6);
    readWord(1, 32'h0000_0244, "R8");
    @(posedge clk); #1;
    sysResetReq = 1;
    @(posedge clk); #1;
    sysResetReq = 0;
    regWr = 1; regWord = 2'd2; regWdata = 32'h0010_0000;
    @(negedge clk);
    check(ejectStrobe, 32'h0, "R8", "no strobe at drain start");
    for (int k = 0; k < 3; k++) begin
      @(posedge clk); #1;
      clearPulses();
      @(negedge clk);
      check(ejectStrobe, drainExp[k], "R8", $sformatf("drain strobe %0d", k));
    end
    readWord(3, 32'hFFFF_FFFC, "R8");
    readWord(1, 32'h0, "R8");
    readWord(0, 32'h0000_0118, "R8");

    repeat (2) @(posedge clk);
    @(negedge clk);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule